// File: doc/BRIEF.md
# Crossing Event Framer

The framer gathers the payload words that a detector front-end produces during one bunch crossing and buffers them. When the crossing closes, it queues a header that describes the crossing. A valid/ready stream toward the link serializer then carries each crossing as one frame: the header word first, followed by the buffered payload words of that crossing. Crossings close at a fixed 40 MHz cadence, which is once every 25 ns.

Each header holds a 12-bit crossing identifier, the count of payload words and a truncation flag. The identifier comes from an internal counter that wraps at 3564. The counter is re-synchronised by a reset command, which loads a programmable preset value. The identifier is attached when the crossing closes, before anything leaves the buffer.

The payload buffer is finite. When it is full, later words of the crossing are discarded and the header is marked as truncated. The words that were already accepted are kept, and the header is still sent. A mode input selects between two kinds of payload. In zero-suppressed mode, words of value zero are removed. In raw mode, every word is kept. In zero-suppressed mode, a crossing with no payload produces no frame unless the header-only option is set. A crossing that closes while the header queue is full produces no frame.

Top module: `evt_framer`

## Requirements
- R1: After reset, out_valid_o is low and the crossing counter is 0, so the first closed crossing carries identifier 0.
- R2: A frame is one header word with out_sof_o high, followed by exactly as many payload words as the header count, with out_eof_o high on the last word. A frame with no payload is a single word with both out_sof_o and out_eof_o high. The header word has the identifier in bits [11:0], the payload word count in bits [19:12] and the truncation flag in bit 20. Payload words are zero-extended.
- R3: The crossing counter advances by one at every crossing close (bx_end_i high) and wraps from 3563 to 0.
- R4: bx_rst_i loads bx_preset_i into the counter. A crossing that closes in the same cycle still carries the value the counter held before the load. The next crossing carries the preset.
- R5: With zs_mode_i high, payload words equal to zero are discarded. With zs_mode_i low, every payload word is kept in arrival order.
- R6: With zs_mode_i high, a crossing with no kept words and no truncation emits no frame unless hdr_only_i is high. With zs_mode_i low, every crossing emits a frame.
- R7: A payload word that finds the 64-word buffer full is discarded, and the words already accepted are kept. The frame's truncation flag is set, and the header is sent even when the count is zero.
- R8: While out_valid_o is high and out_ready_i is low, the output word and markers hold steady, and no word is lost or repeated.
- R9: A payload word presented in the same cycle as bx_end_i belongs to the crossing that is closing.
- R10: Frames leave in the order their crossings closed, and no word appears that was not sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bx_end_i | input | 1 | Closes the current crossing |
| bx_rst_i | input | 1 | Loads the preset into the crossing counter |
| bx_preset_i | input | 12 | Counter preset value |
| word_valid_i | input | 1 | Payload word present |
| word_i | input | 16 | Payload word |
| zs_mode_i | input | 1 | 1: zero-suppressed, 0: raw |
| hdr_only_i | input | 1 | Emit a header for empty zero-suppressed crossings |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream accepts the word |
| out_data_o | output | 21 | Header or payload word |
| out_sof_o | output | 1 | Word is a frame header |
| out_eof_o | output | 1 | Word is the last of its frame |

## Verification
A wrong counter value appears in the very next header as an identifier that breaks the +1, wrap or preset sequence. After that, every later frame carries the same offset until the next reset command. A corrupted buffer pointer or count appears inside the current or following frame as a misplaced payload word, a count that does not match the words that follow it, or a misplaced end marker. A faulty truncation or suppression decision appears in the header of that crossing's own frame as a wrong flag or count, or as a frame that is missing or extra.

// File: rtl/efr_pkg.sv
package efr_pkg;
  localparam int BXID_W = 12;
  localparam int CNT_W  = 8;
  localparam int HDR_W  = 1 + CNT_W + BXID_W;

  typedef struct packed {
    logic              trunc;
    logic [CNT_W-1:0]  cnt;
    logic [BXID_W-1:0] bxid;
  } hdr_t;
endpackage

// File: rtl/efr_bx_counter.sv
module efr_bx_counter #(
  parameter int BXID_W = 12,
  parameter int BX_MAX = 3564
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bx_end_i,
  input  logic              bx_rst_i,
  input  logic [BXID_W-1:0] preset_i,
  output logic [BXID_W-1:0] bx_id_o
);
  localparam logic [BXID_W-1:0] LAST = BXID_W'(BX_MAX - 1);

  logic [BXID_W-1:0] bx_q, bx_inc;

  assign bx_inc  = (bx_q == LAST) ? '0 : bx_q + 1'b1;
  assign bx_id_o = bx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bx_q <= '0;
    else if (bx_rst_i) bx_q <= preset_i;
    else if (bx_end_i) bx_q <= bx_inc;
  end
endmodule

// File: rtl/efr_fifo.sv
module efr_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_q <= (rptr_q == PTR_LAST) ? '0 : rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/efr_ingress.sv
module efr_ingress
  import efr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              zs_mode_i,
  input  logic              hdr_only_i,
  input  logic              bx_end_i,
  input  logic [BXID_W-1:0] bx_id_i,
  input  logic              pay_full_i,
  input  logic              hq_full_i,
  output logic              pay_push_o,
  output logic [DATA_W-1:0] pay_wdata_o,
  output logic              hq_push_o,
  output hdr_t              hq_wdata_o
);
  logic             keep, accept, drop;
  logic [CNT_W-1:0] cnt_q, cnt_f;
  logic             trunc_q, trunc_f;
  logic             nonempty;

  assign keep   = word_valid_i && (!zs_mode_i || (word_i != '0));
  // a word is only taken when its header is sure to find room
  assign accept = keep && !pay_full_i && !hq_full_i;
  assign drop   = keep && !accept;

  assign cnt_f   = cnt_q + CNT_W'(accept);
  assign trunc_f = trunc_q || drop;
  assign nonempty = (cnt_f != '0) || trunc_f;

  assign pay_push_o  = accept;
  assign pay_wdata_o = word_i;

  assign hq_push_o = bx_end_i && !hq_full_i &&
                     (!zs_mode_i || nonempty || hdr_only_i);
  assign hq_wdata_o = '{trunc: trunc_f, cnt: cnt_f, bxid: bx_id_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      trunc_q <= 1'b0;
    end else if (bx_end_i) begin
      cnt_q   <= '0;
      trunc_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_f;
      trunc_q <= trunc_f;
    end
  end
endmodule

// File: rtl/efr_egress.sv
module efr_egress
  import efr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WORD_W = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  hdr_t              hq_rdata_i,
  input  logic              hq_empty_i,
  output logic              hq_pop_o,
  input  logic [DATA_W-1:0] pay_rdata_i,
  output logic              pay_pop_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_data_o,
  output logic              out_sof_o,
  output logic              out_eof_o
);
  typedef enum logic {S_HDR, S_PAY} st_e;

  st_e              st_q;
  logic [CNT_W-1:0] rem_q;
  logic             fire;

  always_comb begin
    if (st_q == S_HDR) begin
      out_valid_o = !hq_empty_i;
      out_sof_o   = 1'b1;
      out_eof_o   = (hq_rdata_i.cnt == '0);
      out_data_o  = WORD_W'(hq_rdata_i);
    end else begin
      out_valid_o = 1'b1;
      out_sof_o   = 1'b0;
      out_eof_o   = (rem_q == CNT_W'(1));
      out_data_o  = WORD_W'(pay_rdata_i);
    end
  end

  assign fire      = out_valid_o && out_ready_i;
  assign hq_pop_o  = fire && (st_q == S_HDR);
  assign pay_pop_o = fire && (st_q == S_PAY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_HDR;
      rem_q <= '0;
    end else if (fire) begin
      if (st_q == S_HDR) begin
        if (hq_rdata_i.cnt != '0) begin
          rem_q <= hq_rdata_i.cnt;
          st_q  <= S_PAY;
        end
      end else begin
        rem_q <= rem_q - 1'b1;
        if (rem_q == CNT_W'(1)) st_q <= S_HDR;
      end
    end
  end
endmodule

// File: rtl/evt_framer.sv
module evt_framer
  import efr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 64,
  parameter int HDR_DEPTH = 16,
  parameter int BX_MAX    = 3564,
  localparam int WORD_W   = (DATA_W > HDR_W) ? DATA_W : HDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bx_end_i,
  input  logic              bx_rst_i,
  input  logic [BXID_W-1:0] bx_preset_i,
  input  logic              word_valid_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              zs_mode_i,
  input  logic              hdr_only_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_data_o,
  output logic              out_sof_o,
  output logic              out_eof_o
);
  logic [BXID_W-1:0] bx_id;
  logic              pay_push, pay_pop, pay_full, pay_empty;
  logic [DATA_W-1:0] pay_wdata, pay_rdata;
  logic              hq_push, hq_pop, hq_full, hq_empty;
  hdr_t              hq_wdata, hq_rdata;
  logic [HDR_W-1:0]  hq_rdata_raw;

  efr_bx_counter #(.BXID_W(BXID_W), .BX_MAX(BX_MAX)) u_bx (
    .clk_i(clk_i), .rst_ni(rst_ni), .bx_end_i(bx_end_i), .bx_rst_i(bx_rst_i),
    .preset_i(bx_preset_i), .bx_id_o(bx_id)
  );

  efr_ingress #(.DATA_W(DATA_W)) u_in (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_valid_i(word_valid_i), .word_i(word_i),
    .zs_mode_i(zs_mode_i), .hdr_only_i(hdr_only_i), .bx_end_i(bx_end_i),
    .bx_id_i(bx_id), .pay_full_i(pay_full), .hq_full_i(hq_full),
    .pay_push_o(pay_push), .pay_wdata_o(pay_wdata),
    .hq_push_o(hq_push), .hq_wdata_o(hq_wdata)
  );

  efr_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_pay (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(pay_push), .wdata_i(pay_wdata),
    .pop_i(pay_pop), .rdata_o(pay_rdata), .full_o(pay_full), .empty_o(pay_empty)
  );

  efr_fifo #(.W(HDR_W), .DEPTH(HDR_DEPTH)) u_hq (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(hq_push), .wdata_i(HDR_W'(hq_wdata)),
    .pop_i(hq_pop), .rdata_o(hq_rdata_raw), .full_o(hq_full), .empty_o(hq_empty)
  );

  assign hq_rdata = hdr_t'(hq_rdata_raw);

  efr_egress #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .hq_rdata_i(hq_rdata), .hq_empty_i(hq_empty),
    .hq_pop_o(hq_pop), .pay_rdata_i(pay_rdata), .pay_pop_o(pay_pop),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
    .out_sof_o(out_sof_o), .out_eof_o(out_eof_o)
  );
endmodule

// File: rtl/efr_chk.sv
module efr_chk
  import efr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BX_MAX = 3564,
  parameter int WORD_W = 21
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bx_end_i,
  input logic              bx_rst_i,
  input logic [BXID_W-1:0] bx_preset_i,
  input logic [BXID_W-1:0] bx_id,
  input logic              pay_push,
  input logic              pay_full,
  input logic              pay_empty,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [WORD_W-1:0] out_data_o,
  input logic              out_sof_o,
  input logic              out_eof_o
);
  logic [CNT_W-1:0]  o_cnt;
  logic [BXID_W-1:0] o_bx;
  assign o_cnt = out_data_o[BXID_W +: CNT_W];
  assign o_bx  = out_data_o[BXID_W-1:0];

  p_preset_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bx_rst_i |=> bx_id == $past(bx_preset_i));

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bx_end_i && !bx_rst_i && bx_id == BXID_W'(BX_MAX - 1)) |=> bx_id == '0);

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_push |-> !pay_full);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      out_valid_o && $stable(out_data_o) && $stable(out_sof_o) && $stable(out_eof_o));

  p_single_hdr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_sof_o) |-> (out_eof_o == (o_cnt == '0)));

  p_bxid_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_sof_o) |-> o_bx < BXID_W'(BX_MAX));

  p_payload_present_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_sof_o) |-> !pay_empty);
endmodule

bind evt_framer efr_chk #(.DATA_W(DATA_W), .BX_MAX(BX_MAX), .WORD_W(WORD_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .bx_end_i(bx_end_i), .bx_rst_i(bx_rst_i),
  .bx_preset_i(bx_preset_i), .bx_id(bx_id), .pay_push(pay_push),
  .pay_full(pay_full), .pay_empty(pay_empty), .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i), .out_data_o(out_data_o), .out_sof_o(out_sof_o),
  .out_eof_o(out_eof_o)
);

// File: tb/evt_framer_tb_top.sv
module evt_framer_tb_top;
  localparam int DEPTH = 64;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bx_end = 0, bxrst = 0, wvalid = 0, zs = 0, hdr_only = 0, ready = 0;
  logic [11:0] preset = '0;
  logic [15:0] wdata = '0;
  logic        out_valid, sof, eof;
  logic [20:0] out_data;

  int total = 0, bad = 0, rdy_pat = 0, cap = DEPTH;
  bit done = 0;
  logic [11:0] bx_model = '0;

  logic [20:0] exp_d[$];
  bit          exp_sof[$], exp_eof[$];
  string       exp_tag[$];

  always #4 clk = ~clk;

  evt_framer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bx_end_i(bx_end), .bx_rst_i(bxrst),
    .bx_preset_i(preset), .word_valid_i(wvalid), .word_i(wdata), .zs_mode_i(zs),
    .hdr_only_i(hdr_only), .out_valid_o(out_valid), .out_ready_i(ready),
    .out_data_o(out_data), .out_sof_o(sof), .out_eof_o(eof)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    case (rdy_pat)
      0: ready = 1'b0;
      1: ready = 1'b1;
      default: ready = ~ready;
    endcase
  end

  always @(negedge clk) begin
    if (rst_n && out_valid && ready) begin
      if (exp_d.size() == 0) begin
        check(0, "R10 unexpected word", int'(out_data), -1);
      end else begin
        check(out_data == exp_d[0] && sof == exp_sof[0] && eof == exp_eof[0],
              exp_tag[0], int'({sof, eof, out_data}), int'({exp_sof[0], exp_eof[0], exp_d[0]}));
        void'(exp_d.pop_front());
        void'(exp_sof.pop_front());
        void'(exp_eof.pop_front());
        void'(exp_tag.pop_front());
      end
    end
  end

  task automatic cyc(input bit be, input bit v, input logic [15:0] d, input bit br);
    @(posedge clk);
    #1;
    bx_end = be; wvalid = v; wdata = d; bxrst = br;
  endtask

  function automatic logic [15:0] gen(input int seed, input int i);
    int k = i * 7 + seed;
    return (k % 4 == 0) ? 16'h0 : 16'(k * 131 + 1);
  endfunction

  // ew: last word shares the closing cycle (R9); rae: preset load in closing cycle
  task automatic do_crossing(input int n, input int seed, input bit z, input bit ho,
                             input bit ew, input bit rae, input string tag);
    logic [15:0] kept[$];
    bit tr = 0;
    int c;
    zs = z; hdr_only = ho;
    for (int i = 0; i < n; i++) begin
      logic [15:0] w = gen(seed, i);
      bit last = ew && (i == n - 1);
      cyc(last, 1, w, last && rae);
      if (!z || w != 0) begin
        if (cap > 0) begin kept.push_back(w); cap--; end
        else tr = 1;
      end
    end
    if (!(ew && n > 0)) cyc(1, 0, '0, rae);
    c = kept.size();
    if (!z || c > 0 || tr || ho) begin
      exp_d.push_back({tr, 8'(c), bx_model});
      exp_sof.push_back(1); exp_eof.push_back(c == 0); exp_tag.push_back(tag);
      for (int j = 0; j < c; j++) begin
        exp_d.push_back({5'b0, kept[j]});
        exp_sof.push_back(0); exp_eof.push_back(j == c - 1); exp_tag.push_back(tag);
      end
    end
    bx_model = rae ? preset : ((bx_model == 12'd3563) ? 12'd0 : bx_model + 12'd1);
    cyc(0, 0, '0, 0);
  endtask

  task automatic drain(input int pat);
    rdy_pat = pat;
    for (int k = 0; k < 3000 && exp_d.size() > 0; k++) @(posedge clk);
    repeat (4) @(posedge clk);
    cap = DEPTH;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 0, "R1 valid in reset", int'(out_valid), 0);
    rst_n = 1;
    repeat (2) @(posedge clk);
    #1;
    check(out_valid == 0, "R1 valid after reset", int'(out_valid), 0);

    // first header after reset carries identifier 0
    rdy_pat = 1;
    do_crossing(0, 0, 0, 0, 0, 0, "R1");
    drain(1);

    // sweep: payload length x mode x header-only x closing alignment
    for (int n = 0; n <= 6; n++) begin
      for (int m = 0; m < 4; m++) begin
        string tag;
        bit z = m[0], ho = m[1], ew = n[0];
        if (n == 0) tag = "R6";
        else if (ew) tag = "R9";
        else if (z) tag = "R5";
        else tag = "R2";
        do_crossing(n, n * 3 + m, z, ho, ew, 0, tag);
        drain(1);
        if (z && !ho && n == 0)
          check(out_valid == 0, "R6 empty suppressed crossing", int'(out_valid), 0);
      end
    end

    // preset, wrap, and load coinciding with a closing crossing
    preset = 12'd3561;
    cyc(0, 0, '0, 1);
    cyc(0, 0, '0, 0);
    bx_model = preset;
    for (int i = 0; i < 4; i++) do_crossing(0, 0, 0, 0, 0, 0, "R3");
    preset = 12'd100;
    do_crossing(2, 5, 0, 0, 1, 1, "R4");
    do_crossing(1, 9, 0, 0, 0, 0, "R4");
    drain(1);

    // truncation with output stalled, then drain under backpressure
    rdy_pat = 0;
    repeat (2) @(posedge clk);
    do_crossing(40, 1, 0, 0, 0, 0, "R7");
    do_crossing(40, 2, 0, 0, 0, 0, "R7");
    do_crossing(5, 3, 0, 0, 1, 0, "R7");
    do_crossing(6, 4, 1, 0, 0, 0, "R7");
    check(out_valid == 1, "R8 held valid while stalled", int'(out_valid), 1);
    drain(2);

    // several frames queued, released in order
    rdy_pat = 0;
    repeat (2) @(posedge clk);
    for (int i = 0; i < 5; i++) do_crossing(2 + i, 20 + i, i % 2, 0, 0, 0, "R10");
    drain(2);
    drain(1);

    check(exp_d.size() == 0, "R10 frames outstanding", exp_d.size(), 0);
    check(out_valid == 0, "R10 idle at end", int'(out_valid), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule